// File: doc/BRIEF.md
# Two-Counter Performance Monitor

This block counts activity inside a processor core. It has a free-running cycle counter and two event counters, all 32 bits wide. Each event counter watches one line of a 256-wide vector of hardware event pulses, and an 8-bit code chosen by software picks that line. A single control word holds every setting: the global run bit, the two clear strobes, the divide-by-64 mode of the cycle counter, one interrupt enable per counter, one sticky overflow flag per counter and the two event codes.

Software reaches the control word and the three counters through a small register port. The port has a 4-bit index, a write strobe, write data and read data that is combinational on the index. A counter that rolls over from all-ones to zero sets its overflow flag. The interrupt line stays high for as long as any flag is set whose enable bit is also set. Software clears a flag by writing the control word with a 1 in that flag's bit.

Top module: `perf_mon`

## Requirements
- R1: Control bit 0 is the run bit. While it is 0, none of the three counters changes unless it is written or cleared.
- R2: Writing the control word with bit 1 set clears both event counters at that edge. Writing it with bit 2 set clears the cycle counter and the divide phase. Both bits always read back as 0.
- R3: With control bit 3 set, the cycle counter advances once every 64 running clocks. The first step comes 64 clocks after a cycle-counter clear. With bit 3 clear, it advances on every running clock.
- R4: Event counter 0 takes its code from control bits 19:12 and event counter 1 from bits 27:20. While running, a counter adds one on each clock where the selected event line is high. Code 0xFF never counts.
- R5: A counter that rolls over from 0xFFFFFFFF to 0 sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter. A flag that is set stays set when another counter overflows.
- R6: Writing the control word with a 1 in an overflow bit clears that flag. A 0 in that bit leaves the flag as it is.
- R7: The interrupt output is high exactly when some flag is set together with its enable bit. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R8: Control bits 7, 11 and 31:28 always read as 0, whatever was written to them.
- R9: Register index 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write to indices 1 to 3 loads that counter, and the load takes priority over counting. Any other index reads 0 and ignores writes.
- R10: After reset, every register reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the indexed register |
| events | input | 256 | Hardware event lines, indexed by event code |
| irq | output | 1 | Level interrupt from the enabled overflow flags |

## Verification
The assertions check on every clock that each counter holds while idle, reads zero after a clear or a roll-over, and takes the loaded value after a write. They also check that a flag stays set until its own clear bit is written, and that the divide phase restarts after each divided step. Only the bench scenarios can show the exact divide-by-64 count over many clocks and the mapping from event codes to lines, including the unused code. They also cover the packing of the control word with its always-zero bits, flags from two counters set one after the other, and the masking of the interrupt by its enables. A reference model in the bench runs beside the design and compares the read data and the interrupt on every clock.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CW      = 32;
  localparam int SELW    = 8;
  localparam int NEV     = 2;
  localparam int NCODE   = 1 << SELW;
  localparam int PREW    = 6;
  localparam int IDX_W   = 4;
  localparam int NFLAG   = NEV + 1;

  // control word bit positions (flag/enable index NEV is the cycle counter)
  localparam int B_RUN   = 0;
  localparam int B_EVCLR = 1;
  localparam int B_CYCLR = 2;
  localparam int B_DIV   = 3;
  localparam int B_IE    = 4;
  localparam int B_OVF   = 8;
  localparam int B_SEL   = 12;

  localparam logic [SELW-1:0]  SEL_NONE = '1;
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_CYC  = IDX_W'(1);
  localparam int               IDX_EV0  = 2;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return v + CW'(1);
  endfunction

  function automatic logic at_top(input logic [CW-1:0] v);
    return &v;
  endfunction

  function automatic logic [NFLAG-1:0] flag_next(input logic [NFLAG-1:0] cur,
                                                 input logic [NFLAG-1:0] clr,
                                                 input logic [NFLAG-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/pm_prescale.sv
module pm_prescale
  import pm_pkg::*;
#(
  parameter int W = PREW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic tick
);
  logic [W-1:0] ph;

  assign tick = step & (&ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph <= '0;
    else if (clr)  ph <= '0;
    else if (step) ph <= ph + W'(1);
  end

  // R3: after a divided step the phase starts over
  p_phase_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr |=> ph == '0);
endmodule

// File: rtl/pm_counter.sv
module pm_counter
  import pm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = inc & ~clr & ~load & at_top(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (inc)   cnt <= bump(cnt);
  end

  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> cnt == $past(load_val));
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !load && !inc |=> $stable(cnt));
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [CW-1:0]             wdata,
  input  logic [NFLAG-1:0]          set_ovf,
  output logic                      run,
  output logic                      div,
  output logic [NFLAG-1:0]          ie,
  output logic [NEV-1:0][SELW-1:0]  sel,
  output logic [NFLAG-1:0]          ovf,
  output logic                      clr_ev,
  output logic                      clr_cyc,
  output logic [CW-1:0]             rd_word
);
  logic [NFLAG-1:0] ack;

  assign clr_ev  = wr_en & wdata[B_EVCLR];
  assign clr_cyc = wr_en & wdata[B_CYCLR];
  assign ack     = wr_en ? wdata[B_OVF +: NFLAG] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      div <= 1'b0;
      ie  <= '0;
      sel <= '0;
      ovf <= '0;
    end else begin
      ovf <= flag_next(ovf, ack, set_ovf);
      if (wr_en) begin
        run <= wdata[B_RUN];
        div <= wdata[B_DIV];
        ie  <= wdata[B_IE +: NFLAG];
        for (int i = 0; i < NEV; i++) sel[i] <= wdata[B_SEL + i*SELW +: SELW];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[B_RUN]          = run;
    rd_word[B_DIV]          = div;
    rd_word[B_IE +: NFLAG]  = ie;
    rd_word[B_OVF +: NFLAG] = ovf;
    for (int i = 0; i < NEV; i++) rd_word[B_SEL + i*SELW +: SELW] = sel[i];
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag_chk
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[g] && !(wr_en && wdata[B_OVF+g]) |=> ovf[g]);
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_ovf[g] |=> ovf[g]);
    p_flag_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wdata[B_OVF+g] && !set_ovf[g] |=> !ovf[g]);
  end
endmodule

// File: rtl/perf_mon.sv
module perf_mon
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       reg_idx,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [255:0]     events,
  output logic             irq
);
  logic                     run, div, clr_ev, clr_cyc;
  logic [NFLAG-1:0]         ie, ovf, set_ovf;
  logic [NEV-1:0][SELW-1:0] sel;
  logic [CW-1:0]            ctrl_word, cyc_cnt;
  logic [NEV-1:0][CW-1:0]   ev_cnt;
  logic [NEV-1:0]           ev_inc, ev_wrap;
  logic                     wr_ctrl, cyc_step, div_tick, cyc_inc, cyc_wrap, cyc_load;

  assign wr_ctrl  = reg_wr && (reg_idx == IDX_CTRL);
  assign cyc_load = reg_wr && (reg_idx == IDX_CYC);
  assign cyc_step = run & div;
  assign cyc_inc  = run & (~div | div_tick);
  assign set_ovf  = {cyc_wrap, ev_wrap};
  assign irq      = |(ovf & ie);

  pm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(reg_wdata),
    .set_ovf(set_ovf), .run(run), .div(div), .ie(ie), .sel(sel),
    .ovf(ovf), .clr_ev(clr_ev), .clr_cyc(clr_cyc), .rd_word(ctrl_word)
  );

  pm_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr_cyc), .step(cyc_step), .tick(div_tick)
  );

  pm_counter u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(clr_cyc), .load(cyc_load),
    .load_val(reg_wdata), .inc(cyc_inc), .cnt(cyc_cnt), .wrap(cyc_wrap)
  );

  for (genvar g = 0; g < NEV; g++) begin : g_ev
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX_EV0 + g);
    logic ld;
    assign ld        = reg_wr && (reg_idx == MY_IDX);
    assign ev_inc[g] = run && (sel[g] != SEL_NONE) && events[sel[g]];

    pm_counter u_ev (
      .clk(clk), .rst_n(rst_n), .clr(clr_ev), .load(ld),
      .load_val(reg_wdata), .inc(ev_inc[g]), .cnt(ev_cnt[g]), .wrap(ev_wrap[g])
    );

    // R4: the unused code freezes the counter apart from writes and clears
    p_unused_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel[g] == SEL_NONE && !ld && !clr_ev |=> $stable(ev_cnt[g]));
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == IDX_CTRL)     reg_rdata = ctrl_word;
    else if (reg_idx == IDX_CYC) reg_rdata = cyc_cnt;
    else begin
      for (int i = 0; i < NEV; i++)
        if (reg_idx == IDX_W'(IDX_EV0 + i)) reg_rdata = ev_cnt[i];
    end
  end

  // R1: stopped counters hold unless written or cleared
  p_stopped_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cyc_load && !clr_cyc |=> $stable(cyc_cnt));
  // R7: with every enable off the interrupt stays low
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ie == '0 |-> !irq);
endmodule

// File: tb/tb_perf_mon.sv
module tb_perf_mon;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   reg_idx = '0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [255:0] events = '0;
  logic         irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  perf_mon dut (.clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
                .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events), .irq(irq));

  // behavioural reference model
  logic [31:0] m_cc, m_e0, m_e1;
  logic [7:0]  m_s0, m_s1;
  logic        m_en, m_div, m_ie0, m_ie1, m_iec, m_ov0, m_ov1, m_ovc;
  int          m_pre;
  logic        t_w0, t_ic, t_i0, t_i1, t_ce, t_cc, t_wc, t_wa, t_wb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cc = 0; m_e0 = 0; m_e1 = 0; m_s0 = 0; m_s1 = 0; m_pre = 0;
      {m_en, m_div, m_ie0, m_ie1, m_iec, m_ov0, m_ov1, m_ovc} = '0;
    end else begin
      t_w0 = reg_wr && reg_idx == 0;
      t_ic = m_en && (!m_div || m_pre == 63);
      t_i0 = m_en && m_s0 != 8'hFF && events[m_s0];
      t_i1 = m_en && m_s1 != 8'hFF && events[m_s1];
      t_ce = t_w0 && reg_wdata[1];
      t_cc = t_w0 && reg_wdata[2];
      t_wc = !t_cc && !(reg_wr && reg_idx == 1) && t_ic && m_cc == 32'hFFFFFFFF;
      t_wa = !t_ce && !(reg_wr && reg_idx == 2) && t_i0 && m_e0 == 32'hFFFFFFFF;
      t_wb = !t_ce && !(reg_wr && reg_idx == 3) && t_i1 && m_e1 == 32'hFFFFFFFF;
      if (t_cc) m_cc = 0; else if (reg_wr && reg_idx == 1) m_cc = reg_wdata; else if (t_ic) m_cc = m_cc + 1;
      if (t_ce) m_e0 = 0; else if (reg_wr && reg_idx == 2) m_e0 = reg_wdata; else if (t_i0) m_e0 = m_e0 + 1;
      if (t_ce) m_e1 = 0; else if (reg_wr && reg_idx == 3) m_e1 = reg_wdata; else if (t_i1) m_e1 = m_e1 + 1;
      if (t_cc) m_pre = 0; else if (m_en && m_div) m_pre = (m_pre + 1) % 64;
      m_ov0 = (m_ov0 && !(t_w0 && reg_wdata[8]))  || t_wa;
      m_ov1 = (m_ov1 && !(t_w0 && reg_wdata[9]))  || t_wb;
      m_ovc = (m_ovc && !(t_w0 && reg_wdata[10])) || t_wc;
      if (t_w0) begin
        m_en = reg_wdata[0]; m_div = reg_wdata[3];
        m_ie0 = reg_wdata[4]; m_ie1 = reg_wdata[5]; m_iec = reg_wdata[6];
        m_s0 = reg_wdata[19:12]; m_s1 = reg_wdata[27:20];
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] i);
    case (i)
      4'd0: return {4'b0, m_s1, m_s0, 1'b0, m_ovc, m_ov1, m_ov0, 1'b0, m_iec, m_ie1, m_ie0, m_div, 3'b000} | {31'b0, m_en};
      4'd1: return m_cc;
      4'd2: return m_e0;
      4'd3: return m_e1;
      default: return 32'h0;
    endcase
  endfunction

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (reg_rdata !== model_rd(reg_idx)) begin
        errors++;
        $display("FAIL R9 model compare idx %0d: got %h expected %h", reg_idx, reg_rdata, model_rd(reg_idx));
      end
      checks++;
      if (irq !== ((m_ov0 && m_ie0) || (m_ov1 && m_ie1) || (m_ovc && m_iec))) begin
        errors++;
        $display("FAIL R7 model compare irq: got %b expected %b", irq,
                 (m_ov0 && m_ie0) || (m_ov1 && m_ie1) || (m_ovc && m_iec));
      end
    end
  end

  task automatic wr(input logic [3:0] i, input logic [31:0] v);
    @(negedge clk); #2;
    reg_idx = i; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd(input logic [3:0] i, input logic [31:0] exp, input string tag);
    @(negedge clk); #2;
    reg_idx = i; #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read idx %0d: got %h expected %h", tag, i, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk); rst_n = 1'b1;
    // R10: reset state
    rd(0, 32'h0, "R10"); rd(1, 32'h0, "R10"); rd(2, 32'h0, "R10");
    rd(3, 32'h0, "R10"); chk_irq(1'b0, "R10");
    // R1: stopped
    edges(10); rd(1, 32'h0, "R1");
    // R1/R2: run with cycle clear, then clear again while stopping
    wr(0, 32'h5); edges(20); rd(1, 32'd20, "R1");
    wr(0, 32'h4); edges(5); rd(1, 32'h0, "R2"); rd(0, 32'h0, "R2");
    // R3: divide by 64
    wr(0, 32'hD); edges(130); rd(1, 32'd2, "R3");
    // R8: always-zero bits; R4: code 0xFF never counts
    wr(0, 32'hFFFF_FFFF); rd(0, 32'h0FFF_F079, "R8");
    events = '1; edges(10);
    @(negedge clk); #2; events = '0;
    rd(2, 32'h0, "R4"); rd(3, 32'h0, "R4");
    // R4: selected events
    wr(0, 32'h0090_5003);
    events[5] = 1'b1; events[9] = 1'b1; edges(3);
    @(negedge clk); #2; events[9] = 1'b0; edges(4);
    @(negedge clk); #2; events = '0;
    rd(2, 32'd7, "R4"); rd(3, 32'd3, "R4");
    // R5/R7: event counter 0 overflow
    wr(2, 32'hFFFF_FFFE); wr(0, 32'h0090_5011);
    events[5] = 1'b1; edges(2);
    @(negedge clk); #2; events = '0;
    rd(2, 32'h0, "R5"); rd(0, 32'h0090_5111, "R5"); chk_irq(1'b1, "R7");
    // R5: second flag while the first is set
    wr(1, 32'hFFFF_FFFF); edges(1);
    rd(0, 32'h0090_5511, "R5");
    // R6: clear flag 8 only; R7: cycle flag masked
    wr(0, 32'h0090_5111); rd(0, 32'h0090_5411, "R6"); chk_irq(1'b0, "R7");
    wr(0, 32'h0090_5051); rd(0, 32'h0090_5451, "R7"); chk_irq(1'b1, "R7");
    wr(0, 32'h0090_5451); rd(0, 32'h0090_5051, "R6"); chk_irq(1'b0, "R6");
    // R9: index map, ignored index, counter load
    wr(4'd5, 32'h1234); rd(4'd5, 32'h0, "R9"); rd(0, 32'h0090_5051, "R9");
    rd(3, 32'd3, "R9");
    wr(3, 32'hABCD); rd(3, 32'hABCD, "R9");
    edges(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule